// File: doc/BRIEF.md
# UART Receive Control-Character Filter

This block sits between a UART receiver's character output and the writer that fills receive buffers. Each received character is compared with a small table of programmable control characters. A shared bit mask decides which bit positions count in the comparison, so one table entry can stand for a whole class of characters.

A character that matches an entry is handled in one of two ways, chosen per entry. It can be passed on with an end-of-message strobe, which closes the current buffer. It can instead be rejected: the character is withheld from the buffer, copied into a last-rejected-character register, and a pending flag is set that drives a maskable interrupt. A character that matches no entry passes through unchanged. All results appear one clock after the character is received. Software sets up the table through a simple register write and read port.

Top module: `uart_ctrlchar_filter`

## Requirements
- R1: After reset, out_valid, out_eom and irq are low, every entry reads 0 (invalid), the mask reads 0x00FF, and the status and control registers read 0.
- R2: A character that matches no entry appears on out_data with out_valid high exactly one cycle after rx_valid, and out_eom stays low. When rx_valid is low, out_valid and out_eom are low in the following cycle.
- R3: The comparison uses only the bit positions whose mask bit is 1. Bits whose mask bit is 0 are don't-care.
- R4: Entries are scanned from index 0 upward, and the scan stops at the first entry whose valid bit is 0. Valid entries above that gap never match.
- R5: A match on an entry whose reject bit is 0 passes the character, and out_eom is high in the same cycle as its out_valid.
- R6: A match on an entry whose reject bit is 1 gives no out_valid and no out_eom. The character is stored in the last-rejected register (address 9), and status bit 0 (address 10) becomes 1.
- R7: A later rejected character overwrites the last-rejected register, whether or not the earlier one was read, and no error is flagged.
- R8: When several valid entries match, the lowest-numbered one decides the action.
- R9: irq equals status bit 0 AND the enable bit (address 11, bit 0). Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A rejection in the same cycle as a clear leaves the bit set.
- R10: Register map: addresses 0 to 7 hold the entries, with the character in bits [7:0], the reject bit in bit 8 and the valid bit in bit 9. Address 8 holds the mask in bits [7:0]. Address 9 holds the last rejected character and is read-only. Address 10 is the status register and address 11 the control register. reg_rdata is combinational from reg_addr, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| out_valid | output | 1 | Character forwarded to the buffer writer |
| out_data | output | 8 | Forwarded character |
| out_eom | output | 1 | End-of-message strobe, aligned with out_valid |
| irq | output | 1 | Level interrupt for a rejected character |

## Verification
Each character is presented for one clock. Its pass-through, end-of-message and rejection effects are all due at the next rising edge: out_valid, out_data and out_eom change there, and so do the last-rejected register, the status bit and irq. The bench drives inputs on falling edges and samples outputs and register reads on the falling edge that follows that single rising edge. Register writes take effect at the next rising edge, so they are read back one falling edge later.

// File: rtl/uart_ctrlchar_filter.sv
module uart_ctrlchar_filter #(
  parameter int CW   = 8,
  parameter int NENT = 8,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          out_valid,
  output logic [CW-1:0] out_data,
  output logic          out_eom,
  output logic          irq
);
  localparam logic [AW-1:0] A_MASK = AW'(NENT);
  localparam logic [AW-1:0] A_LAST = AW'(NENT + 1);
  localparam logic [AW-1:0] A_STAT = AW'(NENT + 2);
  localparam logic [AW-1:0] A_CTRL = AW'(NENT + 3);

  logic [CW-1:0] ent_chr [NENT];
  logic [NENT-1:0] ent_rej, ent_val;
  logic [CW-1:0] mask, last_rej;
  logic          rej_pend, irq_en;
  logic          hit, hit_rej, live;

  always_comb begin
    hit = 1'b0;
    hit_rej = 1'b0;
    live = 1'b1;
    for (int i = 0; i < NENT; i++) begin
      if (!ent_val[i]) live = 1'b0;
      if (live && !hit && (((rx_data ^ ent_chr[i]) & mask) == '0)) begin
        hit = 1'b1;
        hit_rej = ent_rej[i];
      end
    end
  end

  wire rej_now = rx_valid && hit && hit_rej;
  wire clr_now = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_chr[g] <= '0;
        ent_rej[g] <= 1'b0;
        ent_val[g] <= 1'b0;
      end else if (reg_wr && reg_addr == AW'(g)) begin
        ent_chr[g] <= reg_wdata[CW-1:0];
        ent_rej[g] <= reg_wdata[CW];
        ent_val[g] <= reg_wdata[CW+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '1;
      irq_en    <= 1'b0;
      last_rej  <= '0;
      rej_pend  <= 1'b0;
      out_valid <= 1'b0;
      out_eom   <= 1'b0;
      out_data  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == A_CTRL) irq_en <= reg_wdata[0];
      if (rej_now) last_rej <= rx_data;
      if (rej_now) rej_pend <= 1'b1;
      else if (clr_now) rej_pend <= 1'b0;
      out_valid <= rx_valid && !(hit && hit_rej);
      out_eom   <= rx_valid && hit && !hit_rej;
      if (rx_valid) out_data <= rx_data;
    end
  end

  assign irq = rej_pend && irq_en;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_MASK) begin
      for (int i = 0; i < NENT; i++)
        if (reg_addr == AW'(i)) begin
          reg_rdata[CW-1:0] = ent_chr[i];
          reg_rdata[CW]     = ent_rej[i];
          reg_rdata[CW+1]   = ent_val[i];
        end
    end else begin
      case (reg_addr)
        A_MASK:  reg_rdata[CW-1:0] = mask;
        A_LAST:  reg_rdata[CW-1:0] = last_rej;
        A_STAT:  reg_rdata[0] = rej_pend;
        A_CTRL:  reg_rdata[0] = irq_en;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

module uart_ctrlchar_filter_chk #(
  parameter int CW = 8,
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NENT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [CW-1:0] rx_data,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          out_valid,
  input logic [CW-1:0] out_data,
  input logic          out_eom,
  input logic          irq,
  input logic          rej_pend,
  input logic          irq_en,
  input logic [CW-1:0] last_rej
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !out_valid && !out_eom);
  assert_data_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !out_valid || out_data == $past(rx_data));
  assert_eom_on_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eom |-> out_valid);
  assert_reject_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> out_valid || (rej_pend && last_rej == $past(rx_data)));
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rej_pend && irq_en));
  assert_w1c_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rej_pend) |-> $past(reg_wr && reg_addr == AW'(NENT + 2) && reg_wdata[0]));
endmodule

bind uart_ctrlchar_filter uart_ctrlchar_filter_chk #(.CW(CW), .AW(AW), .DW(DW), .NENT(NENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .out_valid(out_valid), .out_data(out_data), .out_eom(out_eom), .irq(irq),
  .rej_pend(rej_pend), .irq_en(irq_en), .last_rej(last_rej)
);

// File: tb/uart_ctrlchar_filter_bench.sv
module uart_ctrlchar_filter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, reg_wr = 1'b0;
  logic [7:0] rx_data = '0, out_data;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic out_valid, out_eom, irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  uart_ctrlchar_filter u_uart_ctrlchar_filter (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    reg_addr = 4'(a);
    #0.5;
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic send(input string req, input int c, input int ev, input int ee);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'(c);
    @(negedge clk);
    rx_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), ev);
    chk({req, " eom"}, int'(out_eom), ee);
    if (ev == 1) chk({req, " data"}, int'(out_data), c);
  endtask

  task automatic clear_table();
    for (int i = 0; i < 8; i++) wr(i, 0);
    wr(8, 'hFF);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_eom", int'(out_eom), 0);
    chk("R1 irq", int'(irq), 0);
    rd("R1 mask", 8, 'hFF);
    rd("R1 entry0", 0, 0);
    rd("R1 entry7", 7, 0);
    rd("R1 status", 10, 0);
    rd("R1 ctrl", 11, 0);
  endtask

  task automatic t_pass();
    send("R2 unmatched", 'h41, 1, 0);
    @(negedge clk);
    chk("R2 idle valid", int'(out_valid), 0);
    wr(1, 'h341);
    rd("R10 entry1 readback", 1, 'h341);
    send("R4 gap stops scan", 'h41, 1, 0);
    rd("R4 status untouched", 10, 0);
    clear_table();
  endtask

  task automatic t_eom();
    wr(0, 'h20D);
    send("R5 eom match", 'h0D, 1, 1);
    send("R5 near miss", 'h0C, 1, 0);
    clear_table();
  endtask

  task automatic t_mask();
    wr(0, 'h310);
    wr(8, 'hF0);
    rd("R10 mask readback", 8, 'hF0);
    send("R3 masked reject", 'h13, 0, 0);
    rd("R6 last rejected", 9, 'h13);
    rd("R6 status set", 10, 1);
    send("R3 upper differs", 'h23, 1, 0);
    wr(10, 1);
    clear_table();
  endtask

  task automatic t_reject_irq();
    wr(0, 'h311);
    wr(1, 'h313);
    send("R6 reject A", 'h11, 0, 0);
    chk("R9 irq disabled", int'(irq), 0);
    wr(11, 1);
    chk("R9 irq enabled", int'(irq), 1);
    send("R7 reject B", 'h13, 0, 0);
    rd("R7 overwrite", 9, 'h13);
    wr(10, 0);
    chk("R9 write zero keeps", int'(irq), 1);
    wr(9, 'h55);
    rd("R10 last read-only", 9, 'h13);
    wr(10, 1);
    chk("R9 w1c clears", int'(irq), 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h11;
    reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 16'd1;
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0;
    chk("R9 set wins over clear", int'(irq), 1);
    wr(10, 1);
    wr(11, 0);
    clear_table();
  endtask

  task automatic t_priority();
    wr(8, 'hF0);
    wr(0, 'h210);
    wr(1, 'h311);
    send("R8 entry0 eom wins", 'h11, 1, 1);
    wr(0, 'h310);
    wr(1, 'h211);
    send("R8 entry0 reject wins", 'h11, 0, 0);
    rd("R8 status", 10, 1);
    wr(10, 1);
    clear_table();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_eom();
    t_mask();
    t_reject_irq();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule